// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block is one channel of a memory copy engine. Software loads a source address, a destination address, an element count and a 16-bit control word through a small register write port. Setting the enable bit arms the channel. An external scheduler, which lies outside this block, decides when a transfer should begin and sends one `start` strobe. The channel then copies the elements one at a time over a simple request/grant memory master port. Each element is a read followed by a write. After each element the channel steps its working addresses by the mode selected for each side.

At the end of a run the channel pulses `done`. It can also pulse `irq`. It either disarms itself or, in repeat mode, stays armed for the next strobe and reloads parts of its state. The `CH` parameter gives the channel index. The index sets the width of the count and the address regions the channel may reach. An element that would touch a forbidden region is dropped without a bus cycle, and a sticky error flag records it.

Top module: `dma_channel_engine`

## Requirements
- R1: After reset, `busy`, `done`, `irq`, `err`, `mem_req` and `ctrl_q` are all zero.
- R2: Register select `wr_sel` chooses 0 = source, 1 = destination, 2 = count, 3 = control. In the control word, bits 6:5 set the destination mode: 0 increment, 1 decrement, 2 fixed, 3 increment with restore on repeat. Bits 8:7 set the source mode: 0 increment, 1 decrement, 2 or 3 fixed. Bit 10 selects 32-bit elements (step 4) over 16-bit elements (step 2). Bits 13:12 are stored and have no effect on the engine.
- R3: Each element is one read (`mem_we`=0) from the source, then one write (`mem_we`=1) of the data just read to the destination. `mem_size` equals control bit 10, and a request holds its address until it is granted.
- R4: Addresses on the bus are the working addresses with bit 0 cleared (16-bit elements) or bits 1:0 cleared (32-bit elements).
- R5: The count is 14 bits for `CH`<3 and 16 bits for `CH`=3. A count of zero moves 2^14 or 2^16 elements respectively.
- R6: When a run ends, `done` pulses for one cycle and `busy` is low. `irq` pulses with it only if control bit 14 is set. If repeat (bit 9) is clear, enable (bit 15) clears.
- R7: With repeat set, enable stays set. The next start reloads the count from the count register. The destination is restored from the destination register only in mode 3. The source continues from where it stopped.
- R8: A 0-to-1 write of the enable bit copies the source, destination and count registers into working copies and clears `err`. Later register writes do not change a run until the next enable rise.
- R9: `start` has no effect while enable is clear or while the channel is busy.
- R10: Address bits [AW-1:AW-4] name a region: 0–7 internal, 8–13 cartridge, 14–15 save memory. Channel 0 may use internal memory only. Channels 1 and 2 may also read cartridge space, and channel 3 may also write it. Save memory is never reachable. An element with a forbidden source or destination issues no bus cycle, sets `err`, and still steps the addresses and consumes one count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | AW | Register write data (control uses bits 15:0) |
| ctrl_q | output | 16 | Current control word |
| start | input | 1 | Start strobe from the scheduler |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| irq | output | 1 | One-cycle interrupt pulse |
| err | output | 1 | Sticky region-violation flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 1 | 1 = 32-bit element, 0 = 16-bit |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with grant |
| mem_gnt | input | 1 | Grant, completes the current request |

## Verification
The sweep runs every destination mode against every source mode and both element sizes, with counts of one to three. Each run starts from unaligned addresses, so a wrong step sign, a wrong step size, a missing alignment mask or a mixed-up mode encoding each shows up as a distinct address error. Alternating and constant grant patterns separate the request-hold logic from the immediate-grant path. Separate scenarios cover:
- a zero count, which tells the maximum-count rule apart from a simple down-counter;
- two repeat runs, which tell restore-on-repeat from plain increment;
- register writes made after arming, which show whether the working copies were latched;
- forbidden and allowed regions, which show whether a dropped element is kept apart from a real transfer.

// File: rtl/dma_channel_engine.sv
module dma_channel_engine #(
  parameter int CH = 3,
  parameter int AW = 28,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic [15:0]   ctrl_q,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output logic          err,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_size,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_gnt
);
  localparam int CW = (CH == 3) ? 16 : 14;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;

  logic [AW-1:0] src_r, dst_r, wsrc, wdst;
  logic [CW-1:0] cnt_r;
  logic [CW:0]   rem;
  logic [15:0]   ctrl_r;
  logic          rearm;
  logic [DW-1:0] dbuf;

  logic          en, wide;
  logic [1:0]    dmode, smode;
  logic [CW:0]   cnt_eff;
  logic [AW-1:0] step, amask, src_al, dst_al, src_nxt, dst_nxt;
  logic          elem_ok, adv, last;

  function automatic logic rd_ok(input logic [3:0] rg);
    return !rg[3] || (rg < 4'd14 && CH >= 1);
  endfunction

  function automatic logic wr_ok(input logic [3:0] rg);
    return !rg[3] || (rg < 4'd14 && CH == 3);
  endfunction

  assign en      = ctrl_r[15];
  assign wide    = ctrl_r[10];
  assign dmode   = ctrl_r[6:5];
  assign smode   = ctrl_r[8:7];
  assign cnt_eff = (cnt_r == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, cnt_r};
  assign step    = wide ? AW'(4) : AW'(2);
  assign amask   = wide ? ~AW'(3) : ~AW'(1);
  assign src_al  = wsrc & amask;
  assign dst_al  = wdst & amask;
  assign src_nxt = (smode == 2'd0) ? wsrc + step : (smode == 2'd1) ? wsrc - step : wsrc;
  assign dst_nxt = (dmode == 2'd1) ? wdst - step : (dmode == 2'd2) ? wdst : wdst + step;
  assign elem_ok = rd_ok(src_al[AW-1:AW-4]) && wr_ok(dst_al[AW-1:AW-4]);
  assign adv     = (st == S_RD && !elem_ok) || (st == S_WR && mem_gnt);
  assign last    = (rem == (CW+1)'(1));

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_RD && elem_ok) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_size  = wide;
  assign mem_addr  = (st == S_WR) ? dst_al : src_al;
  assign mem_wdata = dbuf;
  assign ctrl_q    = ctrl_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src_r <= '0; dst_r <= '0; wsrc <= '0; wdst <= '0;
      cnt_r <= '0; rem <= '0; ctrl_r <= '0; rearm <= 1'b0;
      dbuf <= '0; done <= 1'b0; irq <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      irq  <= 1'b0;
      case (st)
        S_IDLE: if (start && en) begin
          if (rearm) begin
            rem <= cnt_eff;
            if (dmode == 2'd3) wdst <= dst_r;
            rearm <= 1'b0;
          end
          st <= S_RD;
        end
        S_RD: begin
          if (!elem_ok) err <= 1'b1;
          else if (mem_gnt) begin
            dbuf <= mem_rdata;
            st <= S_WR;
          end
        end
        default: ;
      endcase
      if (adv) begin
        wsrc <= src_nxt;
        wdst <= dst_nxt;
        rem  <= rem - 1'b1;
        if (last) begin
          st   <= S_IDLE;
          done <= 1'b1;
          irq  <= ctrl_r[14];
          if (ctrl_r[9]) rearm <= 1'b1;
          else ctrl_r[15] <= 1'b0;
        end else begin
          st <= S_RD;
        end
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: src_r <= wr_data;
          2'd1: dst_r <= wr_data;
          2'd2: cnt_r <= wr_data[CW-1:0];
          default: begin
            ctrl_r <= wr_data[15:0];
            if (wr_data[15] && !en) begin
              wsrc  <= src_r;
              wdst  <= dst_r;
              rem   <= cnt_eff;
              rearm <= 1'b0;
              err   <= 1'b0;
            end
            if (!wr_data[15]) st <= S_IDLE;
          end
        endcase
      end
    end
  end

  p_req_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !wr_en) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_irq_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
  p_disarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ctrl_q[15]) |=> !busy);
  p_no_save_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[AW-1:AW-3] != 3'b111));
  p_cart_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr[AW-1]) |-> (CH == 3));
endmodule

// File: tb/test_dma_channel_engine.sv
`timescale 1ns/1ps
module test_dma_channel_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, start = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [27:0] wr_data = '0;
  logic [15:0] ctrl_q;
  logic        busy, done, irq, err, mem_req, mem_we, mem_size, mem_gnt;
  logic [27:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        gate = 1'b1, slow = 1'b0;

  int nvec = 0, nbad = 0, nw = 0, nr = 0, nirq = 0;
  logic [27:0] wa [64];
  logic [31:0] wd [64];

  always #2 clk = ~clk;

  dma_channel_engine #(.CH(1), .AW(28), .DW(32)) i_dma_channel_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .start(start), .busy(busy), .done(done), .irq(irq), .err(err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt));

  assign mem_gnt   = mem_req & gate;
  assign mem_rdata = {4'hA, mem_addr};

  always @(posedge clk) gate <= slow ? ~gate : 1'b1;

  always @(negedge clk) begin
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        wa[nw % 64] = mem_addr;
        wd[nw % 64] = mem_wdata;
        nw = nw + 1;
      end else nr = nr + 1;
    end
    if (irq) nirq = nirq + 1;
  end

  task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
    nvec++;
    if (a !== e) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  task automatic wreg(input logic [1:0] s, input logic [27:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run(input int maxc);
    int n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && n < maxc) begin @(negedge clk); n++; end
    if (!done) chk("R6 done never seen", 0, 1);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    nvec++; nbad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int bw, br, bi, stp, sd, dd;
    logic [27:0] s0, d0, msk, sa, da;
    logic [15:0] cw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 irq", irq, 0);
    chk("R1 err", err, 0); chk("R1 mem_req", mem_req, 0); chk("R1 ctrl", ctrl_q, 0);

    // R2 R3 R4 R5 R6 sweep over modes, sizes and counts
    s0 = 28'h0100013; d0 = 28'h2000036;
    for (int sz = 0; sz < 2; sz++)
      for (int dm = 0; dm < 4; dm++)
        for (int sm = 0; sm < 4; sm++)
          for (int c = 1; c <= 3; c++) begin
            slow = (c == 2);
            wreg(3, 0); wreg(0, s0); wreg(1, d0); wreg(2, 28'(c));
            cw = 16'h8000 | 16'(dm << 5) | 16'(sm << 7) | 16'(sz << 10)
               | 16'((c & 1) << 14) | 16'(dm << 12);
            wreg(3, {12'h0, cw});
            bw = nw; br = nr; bi = nirq;
            run(100);
            chk("R5 write count", nw - bw, c);
            chk("R3 read count", nr - br, c);
            chk("R6 irq pulses", nirq - bi, c & 1);
            chk("R6 enable cleared", ctrl_q[15], 0);
            stp = sz ? 4 : 2;
            msk = sz ? 28'hFFFFFFC : 28'hFFFFFFE;
            sd = (sm == 0) ? 1 : (sm == 1) ? -1 : 0;
            dd = (dm == 1) ? -1 : (dm == 2) ? 0 : 1;
            for (int k = 0; k < c; k++) begin
              sa = 28'(int'(s0) + sd * k * stp) & msk;
              da = 28'(int'(d0) + dd * k * stp) & msk;
              chk("R2 R4 dest addr", wa[(bw + k) % 64], da);
              chk("R3 R4 data from src", wd[(bw + k) % 64], {4'hA, sa});
            end
          end
    slow = 1'b0;

    // R5 zero count
    wreg(3, 0); wreg(0, 28'h0000000); wreg(1, 28'h1000000); wreg(2, 0); wreg(3, 28'h8000);
    bw = nw;
    run(40000);
    chk("R5 zero count elements", nw - bw, 16384);
    chk("R5 zero count last addr", wa[(bw + 16383) % 64], 28'h1007FFE);

    // R7 repeat with dest restore (mode 3), 32-bit, src increment
    wreg(3, 0); wreg(0, 28'h0300000); wreg(1, 28'h0400000); wreg(2, 2);
    wreg(3, 28'h8660);
    bw = nw; run(100);
    chk("R7 first run count", nw - bw, 2);
    chk("R7 stays armed", ctrl_q[15], 1);
    wreg(2, 3);
    bw = nw; run(100);
    chk("R7 count reloaded", nw - bw, 3);
    chk("R7 dest restored", wa[bw % 64], 28'h0400000);
    chk("R7 src continues", wd[bw % 64], 32'hA0300008);
    // R7 repeat with plain increment destination
    wreg(3, 0); wreg(0, 28'h0300000); wreg(1, 28'h0400000); wreg(2, 1);
    wreg(3, 28'h8600);
    bw = nw; run(100);
    chk("R7 mode0 first dest", wa[bw % 64], 28'h0400000);
    bw = nw; run(100);
    chk("R7 mode0 dest continues", wa[bw % 64], 28'h0400004);
    chk("R7 mode0 one element", nw - bw, 1);

    // R8 latching on enable rise
    wreg(3, 0); wreg(0, 28'h0500000); wreg(1, 28'h0600000); wreg(2, 1); wreg(3, 28'h8000);
    wreg(0, 28'h0700000); wreg(1, 28'h0700100); wreg(2, 3);
    bw = nw; run(100);
    chk("R8 count latched", nw - bw, 1);
    chk("R8 dest latched", wa[bw % 64], 28'h0600000);
    chk("R8 src latched", wd[bw % 64], 32'hA0500000);
    wreg(3, 0); wreg(3, 28'h8000);
    bw = nw; run(100);
    chk("R8 new values on next rise", nw - bw, 3);
    chk("R8 new dest", wa[bw % 64], 28'h0700100);

    // R9 start ignored when disabled
    wreg(3, 0);
    br = nr;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 busy stays low", busy, 0);
    chk("R9 no bus cycles", nr - br, 0);

    // R10 regions for channel 1
    wreg(0, 28'h8000000); wreg(1, 28'h0100000); wreg(2, 2); wreg(3, 28'h8000);
    bw = nw; run(100);
    chk("R10 cart read allowed", nw - bw, 2);
    chk("R10 cart read data", wd[bw % 64], 32'hA8000000);
    chk("R10 no err", err, 0);
    wreg(3, 0); wreg(0, 28'h0100000); wreg(1, 28'h9000000); wreg(3, 28'h8000);
    bw = nw; br = nr; run(100);
    chk("R10 cart write blocked", nw - bw, 0);
    chk("R10 no read either", nr - br, 0);
    chk("R10 err set", err, 1);
    chk("R10 enable cleared after skip", ctrl_q[15], 0);
    wreg(0, 28'hE000000); wreg(1, 28'h0100000); wreg(3, 28'h8000);
    chk("R8 err cleared on enable", err, 0);
    br = nr; run(100);
    chk("R10 save read blocked", nr - br, 0);
    chk("R10 save err", err, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule